// File: doc/BRIEF.md
# I2C Control Register Slave

This block is an I2C target that holds eight 8-bit control registers for the logic around it. Seven of them can be read and written, and their contents leave the block on a flat output bus. The eighth is a read-only window onto a status byte that other logic supplies. A master reaches a register with three bytes. The first is the device address. The second is an index byte that carries a 3-bit register number and a read-back flag. The third is either a data byte, or a repeated START that turns the transaction into a read.

Both bus lines pass through two-flop synchronizers on the system clock. Every bus event comes from the synchronized lines: START, STOP, SCL rising and SCL falling. A single enumerated state machine steps through the bus phases. Its states are IDLE, ADDR, ADDR_ACK, INDEX, INDEX_ACK, WDATA, WDATA_ACK, RDATA, RDATA_ACK and IGNORE.

The transitions are:
- START moves any state to ADDR, and STOP moves any state to IDLE.
- At the SCL fall that ends the eighth address bit, ADDR goes to ADDR_ACK on an address match and to IGNORE on a mismatch.
- ADDR_ACK goes to RDATA for a read and to INDEX for a write.
- INDEX goes to INDEX_ACK, then to WDATA. WDATA goes to WDATA_ACK.
- WDATA_ACK goes to RDATA when read-back is set, and to IGNORE otherwise.
- RDATA goes to RDATA_ACK after eight bits. RDATA_ACK goes back to RDATA on a master ACK and to IGNORE on a master NACK.

IDLE and IGNORE leave only on START. The slave pulls SDA low through the `sda_oe` output, and the line itself is an open-drain wire outside the block.

Top module: `i2c_regbank`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the register outputs hold their reset image: register 2 is 0x33 and registers 0, 1, 3, 4, 5 and 6 are 0x00. `sda_oe` is low.
- R2: The address byte 0011010 followed by R/W=0 (byte 0x34), and the same address with R/W=1 (byte 0x35), are acknowledged: SDA is held low during the ninth SCL high phase. `sda_oe` only ever changes while SCL is low.
- R3: After an address byte with any other address, no ACK is given. Every later bit is ignored until the next START, so no register changes.
- R4: In a write, the index byte carries the register number in bits 2:0 and don't-care bits in 7:4. The slave ACKs the index byte and the data byte. The data byte, taken MSB first, lands in that register before STOP, and `cfg_regs` changes only while SCL is low.
- R5: A normal read works as follows. Index byte with bit 3 = 0, repeated START, then address with R/W=1. The slave returns the selected register MSB first.
- R6: When bit 3 of the index byte is 1, the ACKed data byte is written. The slave then sends the register's new contents in the next byte of the same transaction.
- R7: Index 7 reads the current `status_in` value. A data byte sent to index 7 is ACKed but leaves every register unchanged.
- R8: Unused bits always read 0 and are forced to 0 on a write. These are register 1 bit 2, register 4 bit 5, register 5 bit 6 and register 6 bits 5:0.
- R9: After a data byte sent by the slave, a master ACK makes the slave send the same register again. A master NACK makes the slave release SDA and ignore further clocks until START.
- R10: A START in the middle of any byte restarts the address phase. A complete transaction that follows it works normally.
- R11: Driving `rst_n` low in the middle of a transaction restores the reset image at once and releases SDA. The next transaction then works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also samples the bus lines |
| rst_n | input | 1 | Active-low power-down/reset; clears registers and bus logic |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired value) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| status_in | input | 8 | Value returned for the read-only register 7 |
| cfg_regs | output | 56 | Registers 0..6, register n in bits 8n+7:8n |

## Verification
On every cycle the checker confirms four things. SDA drive and register contents change only while SCL is low. Unused bits of the exported registers stay zero. The slave never drives SDA while it is ignoring the bus. It also checks the reset image on the first cycle out of reset. Everything that depends on byte content and ordering can only be shown by the bench's transactions. That covers address matching, index decoding, the read-back turnaround, repeated sends after a master ACK, aborts by START or by reset, and write protection of the status register.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } bus_state_e;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = 4;

    // Default reset image, register 0 in the low byte; register 2 powers up as 0x33.
    localparam logic [63:0] DEF_RESET_IMAGE = 64'h0000_0000_0033_0000;
    // Writable bits per register; cleared positions are unused and always zero.
    localparam logic [63:0] DEF_WRITE_MASK  = 64'h00C0_BFDF_FFFF_FBFF;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;
    logic            scl_now;
    logic            scl_prev;
    logic            sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_in};
        end
    end

    assign scl_now  = scl_pipe[STAGES-1];
    assign scl_prev = scl_pipe[STAGES];
    assign sda_s    = sda_pipe[STAGES-1];
    assign sda_prev = sda_pipe[STAGES];

    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign start_evt = scl_now & scl_prev & sda_prev & ~sda_s;
    assign stop_evt  = scl_now & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/i2c_reg_store.sv
module i2c_reg_store #(
    parameter int                     REG_COUNT   = 8,
    parameter int                     IDX_W       = 3,
    parameter logic [REG_COUNT*8-1:0] RESET_IMAGE = '0,
    parameter logic [REG_COUNT*8-1:0] WRITE_MASK  = '1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [7:0]                 wr_data,
    input  logic [IDX_W-1:0]           rd_idx,
    input  logic [7:0]                 status_in,
    output logic [7:0]                 rd_data,
    output logic [(REG_COUNT-1)*8-1:0] regs_out
);

    logic [7:0] view [REG_COUNT];

    for (genvar g = 0; g < REG_COUNT - 1; g++) begin : g_reg
        logic [7:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= RESET_IMAGE[g*8 +: 8];
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                q <= wr_data & WRITE_MASK[g*8 +: 8];
            end
        end

        assign view[g]           = q;
        assign regs_out[g*8 +: 8] = q;
    end

    // The top index is the read-only status window.
    assign view[REG_COUNT-1] = status_in;
    assign rd_data           = view[rd_idx];

endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank
    import i2c_regbank_pkg::*;
#(
    parameter logic [6:0]             DEVICE_ADDR = 7'b0011010,
    parameter int                     REG_COUNT   = 8,
    parameter int                     RB_BIT      = 3,
    parameter logic [REG_COUNT*8-1:0] RESET_IMAGE = DEF_RESET_IMAGE,
    parameter logic [REG_COUNT*8-1:0] WRITE_MASK  = DEF_WRITE_MASK
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_in,
    input  logic                       sda_in,
    output logic                       sda_oe,
    input  logic [7:0]                 status_in,
    output logic [(REG_COUNT-1)*8-1:0] cfg_regs
);

    localparam int IDX_W = $clog2(REG_COUNT);
    localparam int CFG_W = (REG_COUNT - 1) * BYTE_W;

    logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;

    bus_state_e             state_q, state_d;
    logic [BIT_CNT_W-1:0]   bit_cnt_q;
    logic [BYTE_W-1:0]      rx_q;
    logic [BYTE_W-1:0]      tx_q;
    logic [IDX_W-1:0]       idx_q;
    logic                   rb_q;
    logic                   rw_q;
    logic                   mack_q;
    logic                   sda_oe_q;
    logic                   wr_en_q;
    logic [BYTE_W-1:0]      rd_data;
    logic                   byte_done;
    logic                   addr_hit;
    logic                   ignoring;

    i2c_line_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_reg_store #(
        .REG_COUNT   (REG_COUNT),
        .IDX_W       (IDX_W),
        .RESET_IMAGE (RESET_IMAGE),
        .WRITE_MASK  (WRITE_MASK)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en_q),
        .wr_idx    (idx_q),
        .wr_data   (rx_q),
        .rd_idx    (idx_q),
        .status_in (status_in),
        .rd_data   (rd_data),
        .regs_out  (cfg_regs)
    );

    assign byte_done = (bit_cnt_q == BIT_CNT_W'(BYTE_W));
    assign addr_hit  = (rx_q[7:1] == DEVICE_ADDR);
    assign ignoring  = (state_q == ST_IGNORE);
    assign sda_oe    = sda_oe_q;

    // Next-state logic: bus events from the synchronizer steer the phases.
    always_comb begin
        state_d = state_q;
        if (start_evt) begin
            state_d = ST_ADDR;
        end else if (stop_evt) begin
            state_d = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_ADDR:       if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:   state_d = rw_q ? ST_RDATA : ST_INDEX;
                ST_INDEX:      if (byte_done) state_d = ST_INDEX_ACK;
                ST_INDEX_ACK:  state_d = ST_WDATA;
                ST_WDATA:      if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK:  state_d = rb_q ? ST_RDATA : ST_IGNORE;
                ST_RDATA:      if (bit_cnt_q == BIT_CNT_W'(BYTE_W - 1)) state_d = ST_RDATA_ACK;
                ST_RDATA_ACK:  state_d = mack_q ? ST_RDATA : ST_IGNORE;
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Bit engine and outputs: sample on SCL rise, drive on SCL fall.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            idx_q     <= '0;
            rb_q      <= 1'b0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            sda_oe_q  <= 1'b0;
            wr_en_q   <= 1'b0;
        end else begin
            wr_en_q <= 1'b0;
            if (start_evt) begin
                bit_cnt_q <= '0;
                sda_oe_q  <= 1'b0;
            end else if (stop_evt) begin
                sda_oe_q  <= 1'b0;
            end else if (scl_rise) begin
                unique case (state_q)
                    ST_ADDR, ST_INDEX, ST_WDATA: begin
                        rx_q      <= {rx_q[BYTE_W-2:0], sda_s};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                    ST_RDATA_ACK: mack_q <= ~sda_s;
                    default: ;
                endcase
            end else if (scl_fall) begin
                unique case (state_q)
                    ST_ADDR: begin
                        if (byte_done) begin
                            bit_cnt_q <= '0;
                            rw_q      <= rx_q[0];
                            sda_oe_q  <= addr_hit;
                        end
                    end
                    ST_ADDR_ACK: begin
                        bit_cnt_q <= '0;
                        if (rw_q) begin
                            tx_q     <= rd_data;
                            sda_oe_q <= ~rd_data[BYTE_W-1];
                        end else begin
                            sda_oe_q <= 1'b0;
                        end
                    end
                    ST_INDEX: begin
                        if (byte_done) begin
                            idx_q    <= rx_q[IDX_W-1:0];
                            rb_q     <= rx_q[RB_BIT];
                            sda_oe_q <= 1'b1;
                        end
                    end
                    ST_INDEX_ACK: begin
                        bit_cnt_q <= '0;
                        sda_oe_q  <= 1'b0;
                    end
                    ST_WDATA: begin
                        if (byte_done) begin
                            wr_en_q  <= 1'b1;
                            sda_oe_q <= 1'b1;
                        end
                    end
                    ST_WDATA_ACK: begin
                        bit_cnt_q <= '0;
                        if (rb_q) begin
                            tx_q     <= rd_data;
                            sda_oe_q <= ~rd_data[BYTE_W-1];
                        end else begin
                            sda_oe_q <= 1'b0;
                        end
                    end
                    ST_RDATA: begin
                        if (bit_cnt_q == BIT_CNT_W'(BYTE_W - 1)) begin
                            sda_oe_q <= 1'b0;
                        end else begin
                            tx_q      <= {tx_q[BYTE_W-2:0], 1'b0};
                            sda_oe_q  <= ~tx_q[BYTE_W-2];
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                    ST_RDATA_ACK: begin
                        bit_cnt_q <= '0;
                        if (mack_q) begin
                            tx_q     <= rd_data;
                            sda_oe_q <= ~rd_data[BYTE_W-1];
                        end else begin
                            sda_oe_q <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_regbank_chk.sv
module i2c_regbank_chk #(
    parameter int               CFG_W = 56,
    parameter logic [CFG_W-1:0] RST   = '0,
    parameter logic [CFG_W-1:0] MASK  = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_in,
    input logic             sda_oe,
    input logic             ignoring,
    input logic [CFG_W-1:0] cfg_regs
);

    // R1
    reset_image_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cfg_regs == RST);

    // R2
    drive_in_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_in);

    // R3
    silent_when_ignoring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ignoring |-> !sda_oe);

    // R4
    write_in_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_regs) |-> !scl_in);

    // R8
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_regs & ~MASK) == '0);

endmodule

bind i2c_regbank i2c_regbank_chk #(
    .CFG_W (CFG_W),
    .RST   (RESET_IMAGE[CFG_W-1:0]),
    .MASK  (WRITE_MASK[CFG_W-1:0])
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_oe   (sda_oe),
    .ignoring (ignoring),
    .cfg_regs (cfg_regs)
);

// File: tb/i2c_regbank_test.sv
module i2c_regbank_test;

    localparam int Q = 10;
    localparam logic [55:0] RST_IMG = 56'h00_0000_0033_0000;
    // {index[2:0], written byte, expected read-back}
    localparam logic [18:0] VEC [7] = '{
        {3'd0, 8'hA5, 8'hA5},
        {3'd1, 8'hFF, 8'hFB},
        {3'd2, 8'h12, 8'h12},
        {3'd3, 8'hC3, 8'hC3},
        {3'd4, 8'hFF, 8'hDF},
        {3'd5, 8'hFF, 8'hBF},
        {3'd6, 8'hFF, 8'hC0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [7:0]  status_val = 8'h5A;
    logic        sda_oe;
    logic        sda_line;
    logic [55:0] cfg;
    int          checks = 0;
    int          errors = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_regbank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .status_in (status_val),
        .cfg_regs  (cfg)
    );

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic bus_bit(input logic b, output logic got);
        sda_m = b;    wait_q();
        scl_m = 1'b1; wait_q();
        got = sda_line;
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic g;
        for (int i = 7; i >= 0; i--) bus_bit(v[i], g);
        bus_bit(1'b1, g);
        acked = ~g;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic g;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, g);
            v[i] = g;
        end
        bus_bit(~mack, g);
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] d, input string tag);
        logic a;
        bus_start();
        send_byte(8'h34, a); check({tag, " R2 address ack"}, 64'(a), 64'd1);
        send_byte(idx, a);   check({tag, " index ack"}, 64'(a), 64'd1);
        send_byte(d, a);     check({tag, " data ack"}, 64'(a), 64'd1);
        bus_stop();
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
        logic a;
        bus_start();
        send_byte(8'h34, a);
        send_byte(idx, a);
        bus_start();
        send_byte(8'h35, a); check("R2 read address ack", 64'(a), 64'd1);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0]  rd;
        logic [7:0]  rd2;
        logic        a;
        logic        g;
        logic [55:0] snap;

        repeat (5) @(negedge clk);
        check("R1 reset image", 64'(cfg), 64'(RST_IMG));
        check("R1 sda released in reset", 64'(sda_oe), 64'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 image after reset", 64'(cfg), 64'(RST_IMG));

        // R4 R5 R8: table walk, write then normal read
        for (int v = 0; v < 7; v++) begin
            reg_write({5'd0, VEC[v][18:16]}, VEC[v][15:8], "R4 vector");
            check("R4 cfg after write", 64'(cfg[VEC[v][18:16]*8 +: 8]), 64'(VEC[v][7:0]));
            reg_read({5'd0, VEC[v][18:16]}, rd);
            check("R5 R8 read value", 64'(rd), 64'(VEC[v][7:0]));
        end

        // R7: status window and write protection
        snap = cfg;
        reg_write(8'h07, 8'h11, "R7 status write");
        check("R7 registers unchanged", 64'(cfg), 64'(snap));
        reg_read(8'h07, rd);
        check("R7 status read", 64'(rd), 64'h5A);
        status_val = 8'hC4;
        reg_read(8'h07, rd);
        check("R7 status follows input", 64'(rd), 64'hC4);

        // R3: foreign address gets no ACK and nothing is written
        bus_start();
        send_byte(8'h36, a); check("R3 no ack on foreign address", 64'(a), 64'd0);
        send_byte(8'h00, a); check("R3 no ack on later byte", 64'(a), 64'd0);
        send_byte(8'h00, a); check("R3 no ack on data", 64'(a), 64'd0);
        bus_stop();
        check("R3 register 0 unchanged", 64'(cfg[7:0]), 64'hA5);

        // R6: read-back mode with don't-care upper index bits
        bus_start();
        send_byte(8'h34, a);
        send_byte(8'hFB, a); check("R6 index ack", 64'(a), 64'd1);
        send_byte(8'h3C, a); check("R6 data ack", 64'(a), 64'd1);
        recv_byte(1'b0, rd);
        bus_stop();
        check("R6 read-back value", 64'(rd), 64'h3C);
        check("R6 register 3 written", 64'(cfg[31:24]), 64'h3C);
        bus_start();
        send_byte(8'h34, a);
        send_byte(8'h0E, a);
        send_byte(8'hFF, a);
        recv_byte(1'b0, rd);
        bus_stop();
        check("R6 R8 read-back masked", 64'(rd), 64'hC0);

        // R9: master ACK repeats, NACK releases
        bus_start();
        send_byte(8'h34, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte(8'h35, a);
        recv_byte(1'b1, rd);
        recv_byte(1'b0, rd2);
        recv_byte(1'b0, snap[7:0]);
        bus_stop();
        check("R9 first byte", 64'(rd), 64'hA5);
        check("R9 repeat after ACK", 64'(rd2), 64'hA5);
        check("R9 released after NACK", 64'(snap[7:0]), 64'hFF);

        // R10: START inside the index byte restarts the address phase
        bus_start();
        send_byte(8'h34, a);
        for (int i = 0; i < 4; i++) bus_bit(1'b0, g);
        reg_write(8'h02, 8'h77, "R10 after restart");
        check("R10 register 2 written", 64'(cfg[23:16]), 64'h77);

        // R11: reset in the middle of a data byte
        bus_start();
        send_byte(8'h34, a);
        send_byte(8'h00, a);
        for (int i = 0; i < 4; i++) bus_bit(1'b1, g);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 image restored", 64'(cfg), 64'(RST_IMG));
        check("R11 sda released", 64'(sda_oe), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_stop();
        reg_write(8'h00, 8'h5E, "R11 after reset");
        reg_read(8'h00, rd);
        check("R11 read after reset", 64'(rd), 64'h5E);

        finish_run();
    end

endmodule